// File: doc/BRIEF.md
# Lockable GPIO Configuration Register File

This block holds the configuration state for a bank of general-purpose I/O pins and for a global function-select field. Each pin has one byte-wide register. It carries the pin's output enable, output driver type (push-pull or open-drain), static pull-up enable and driven output value. The stored values drive the pad-control outputs of the block directly. A host writes and reads these registers through a plain strobe interface: address, write data, write enable and combinational read data.

Each pin register and the global register carry a protection bit. Setting that bit freezes the fields it guards until the asynchronous active-low hardware reset. Software cannot clear a protection bit. Firmware typically programs the pins, sets the lock bits once and leaves the configuration fixed. A writer that runs later is then silently ignored. Locking is optional, and a design that never sets a lock keeps every field writable.

Top module: `gpio_cfg_lock_top`

## Requirements
- R1: While `rstN` is low, and asynchronously with it, every attribute bit, every function-select bit and every lock bit is cleared to 0. Every register then reads 0 and every pad-control output is 0.
- R2: A write to pin register address i (0 to NUM_PINS-1) on an unlocked pin stores four fields: bit 0 output enable, bit 1 output type (1 = open-drain), bit 2 pull-up, bit 3 output data. Bits 4 to 6 are not stored and read as 0.
- R3: Reading pin address i returns {lock, 3'b000, data, pull-up, type, enable} for that pin, whether or not the pin is locked.
- R4: Bit 7 of a pin register is the pin lock. A write that sets it also stores that write's four attributes. Every later write to that pin leaves its attributes unchanged.
- R5: A lock on one pin has no effect on writes to any other pin.
- R6: Once set, a pin lock stays 1 through any write, including a write of 0. Only `rstN` clears it.
- R7: Address NUM_PINS is the global register. Bits FSEL_W-1 to 0 hold the function-select field, and bit 7 is the global lock. A write that sets the lock also stores that write's select value. From then on the select field ignores writes.
- R8: Once set, the global lock stays 1 through any write. Only `rstN` clears it.
- R9: The global lock does not protect pin registers, and pin locks do not protect the global register.
- R10: A write to an address above NUM_PINS changes nothing. A read of such an address returns 0.
- R11: The outputs `pinOe`, `pinOpenDrain`, `pinPullUp`, `pinDout` and `funcSel` show the stored fields. They change at the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | 8 | Write data |
| regWe | input | 1 | Write strobe, sampled at the rising edge |
| regRdata | output | 8 | Read data for `regAddr` (combinational) |
| pinOe | output | NUM_PINS | Per-pin output enable |
| pinOpenDrain | output | NUM_PINS | Per-pin output type, 1 = open-drain |
| pinPullUp | output | NUM_PINS | Per-pin static pull-up enable |
| pinDout | output | NUM_PINS | Per-pin driven data |
| funcSel | output | FSEL_W | Global function-select field |

## Verification
The bench uses the default parameters: NUM_PINS = 16, ADDR_W = 5 and FSEL_W = 7. The 5-bit address space leaves addresses 17 to 31 unmapped, so writes and reads outside the register map can be exercised next to the last pin and the global register. With sixteen pins, a random write stream locks some pins while others stay open. This tests per-pin isolation, and a reset partway through the run shows that the locks clear.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

  // Widest pin index supported by the strobe struct (up to 64 pins)
  localparam int PIN_IDX_W = 6;

  // Register bit positions, fixed by the software-visible layout
  localparam int BIT_OE   = 0;
  localparam int BIT_TYPE = 1;
  localparam int BIT_PU   = 2;
  localparam int BIT_DOUT = 3;
  localparam int BIT_LOCK = 7;

  typedef struct packed {
    logic oe;
    logic openDrain;
    logic pullUp;
    logic dout;
  } pin_attr_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 pinWr;   // accepted write to a pin register
    logic                 fselWr;  // accepted write to the global register
    logic                 pinHit;  // address selects a pin register
    logic                 fselHit; // address selects the global register
    logic [PIN_IDX_W-1:0] pinIdx;  // pin index decoded from the address
  } cfg_strobe_t;

endpackage

// File: rtl/gpio_cfg_ctrl.sv
module gpio_cfg_ctrl
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 5
) (
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWe,
  input  logic [NUM_PINS-1:0] pinLock,
  input  logic                globalLock,
  output cfg_strobe_t         strobe
);

  localparam logic [ADDR_W-1:0] FSEL_ADDR = ADDR_W'(NUM_PINS);

  logic                 addrIsPin;
  logic                 addrIsFsel;
  logic [PIN_IDX_W-1:0] idx;
  logic                 selLocked;

  always_comb begin
    addrIsPin  = (regAddr < FSEL_ADDR);
    addrIsFsel = (regAddr == FSEL_ADDR);
    idx        = PIN_IDX_W'(regAddr);
    selLocked  = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (idx == PIN_IDX_W'(i)) selLocked = pinLock[i];
    end
  end

  always_comb begin
    strobe.pinHit  = addrIsPin;
    strobe.fselHit = addrIsFsel;
    strobe.pinIdx  = idx;
    strobe.pinWr   = regWe && addrIsPin && !selLocked;
    strobe.fselWr  = regWe && addrIsFsel && !globalLock;
  end

  // R10: at most one register target is written per cycle
  always_comb begin
    p_one_target_r10: assert ($onehot0({strobe.pinWr, strobe.fselWr}));
  end

endmodule

// File: rtl/gpio_cfg_dp.sv
module gpio_cfg_dp
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int FSEL_W   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfg_strobe_t         strobe,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  output logic [NUM_PINS-1:0] pinLock,
  output logic                globalLock,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinOpenDrain,
  output logic [NUM_PINS-1:0] pinPullUp,
  output logic [NUM_PINS-1:0] pinDout,
  output logic [FSEL_W-1:0]   funcSel
);

  pin_attr_t         attrQ [NUM_PINS];
  logic [FSEL_W-1:0] fselQ;
  logic              unusedWdata;

  assign unusedWdata = ^wdata;

  // Per-pin registers
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        attrQ[i]   <= '0;
        pinLock[i] <= 1'b0;
      end else if (strobe.pinWr && strobe.pinIdx == PIN_IDX_W'(i)) begin
        attrQ[i].oe        <= wdata[BIT_OE];
        attrQ[i].openDrain <= wdata[BIT_TYPE];
        attrQ[i].pullUp    <= wdata[BIT_PU];
        attrQ[i].dout      <= wdata[BIT_DOUT];
        pinLock[i]         <= wdata[BIT_LOCK];
      end
    end

    assign pinOe[i]        = attrQ[i].oe;
    assign pinOpenDrain[i] = attrQ[i].openDrain;
    assign pinPullUp[i]    = attrQ[i].pullUp;
    assign pinDout[i]      = attrQ[i].dout;

    // R4: a locked pin keeps its attributes; R6: and its lock
    p_pin_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
      $past(pinLock[i]) |-> ($stable(attrQ[i]) && pinLock[i]));
  end

  // Global function-select register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fselQ      <= '0;
      globalLock <= 1'b0;
    end else if (strobe.fselWr) begin
      fselQ      <= wdata[FSEL_W-1:0];
      globalLock <= wdata[BIT_LOCK];
    end
  end

  assign funcSel = fselQ;

  // Read mux
  always_comb begin
    rdata = '0;
    if (strobe.pinHit) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (strobe.pinIdx == PIN_IDX_W'(i)) begin
          rdata[BIT_OE]   = attrQ[i].oe;
          rdata[BIT_TYPE] = attrQ[i].openDrain;
          rdata[BIT_PU]   = attrQ[i].pullUp;
          rdata[BIT_DOUT] = attrQ[i].dout;
          rdata[BIT_LOCK] = pinLock[i];
        end
      end
    end else if (strobe.fselHit) begin
      rdata[FSEL_W-1:0] = fselQ;
      rdata[BIT_LOCK]   = globalLock;
    end
  end

  // R8: global lock is sticky
  p_glock_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(globalLock) |-> globalLock);

  // R7: locked select field holds its value
  p_fsel_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(globalLock) |-> $stable(fselQ));

  // R6: no pin lock bit ever falls outside reset
  p_locks_never_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (($past(pinLock) & ~pinLock) == '0));

endmodule

// File: rtl/gpio_cfg_lock_top.sv
module gpio_cfg_lock_top
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 5,
  parameter int FSEL_W   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [7:0]          regWdata,
  input  logic                regWe,
  output logic [7:0]          regRdata,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinOpenDrain,
  output logic [NUM_PINS-1:0] pinPullUp,
  output logic [NUM_PINS-1:0] pinDout,
  output logic [FSEL_W-1:0]   funcSel
);

  cfg_strobe_t         strobe;
  logic [NUM_PINS-1:0] pinLock;
  logic                globalLock;

  gpio_cfg_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_ctrl (
    .regAddr   (regAddr),
    .regWe     (regWe),
    .pinLock   (pinLock),
    .globalLock(globalLock),
    .strobe    (strobe)
  );

  gpio_cfg_dp #(.NUM_PINS(NUM_PINS), .FSEL_W(FSEL_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wdata       (regWdata),
    .rdata       (regRdata),
    .pinLock     (pinLock),
    .globalLock  (globalLock),
    .pinOe       (pinOe),
    .pinOpenDrain(pinOpenDrain),
    .pinPullUp   (pinPullUp),
    .pinDout     (pinDout),
    .funcSel     (funcSel)
  );

endmodule

// File: tb/sim_gpio_cfg_lock_top.sv
module sim_gpio_cfg_lock_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int AW = 5;
  localparam int FW = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [7:0]    regWdata = '0;
  logic          regWe = 1'b0;
  logic [7:0]    regRdata;
  logic [NP-1:0] pinOe, pinOpenDrain, pinPullUp, pinDout;
  logic [FW-1:0] funcSel;

  int checks = 0;
  int errors = 0;

  // Reference model
  logic [3:0]    mAttr [NP];
  logic          mLock [NP];
  logic [FW-1:0] mFsel;
  logic          mGlock;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_cfg_lock_top #(.NUM_PINS(NP), .ADDR_W(AW), .FSEL_W(FW)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .pinOe(pinOe),
    .pinOpenDrain(pinOpenDrain), .pinPullUp(pinPullUp), .pinDout(pinDout),
    .funcSel(funcSel)
  );

  function automatic logic [7:0] expRead(int a);
    logic [7:0] r = '0;
    if (a < NP) r = {mLock[a], 3'b000, mAttr[a]};
    else if (a == NP) r = {mGlock, mFsel};
    return r;
  endfunction

  function automatic logic [4*NP-1:0] expPads();
    logic [4*NP-1:0] v;
    for (int i = 0; i < NP; i++) begin
      v[i]        = mAttr[i][0];
      v[NP+i]     = mAttr[i][1];
      v[2*NP+i]   = mAttr[i][2];
      v[3*NP+i]   = mAttr[i][3];
    end
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NP; i++) begin
      mAttr[i] = '0;
      mLock[i] = 1'b0;
    end
    mFsel  = '0;
    mGlock = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    #2 rstN = 1'b0;
    modelReset();
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(int a, logic [7:0] d);
    @(negedge clk);
    regAddr  = AW'(a);
    regWdata = d;
    regWe    = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    if (a < NP) begin
      if (!mLock[a]) begin
        mAttr[a] = d[3:0];
        mLock[a] = d[7];
      end
    end else if (a == NP) begin
      if (!mGlock) begin
        mFsel  = d[FW-1:0];
        mGlock = d[7];
      end
    end
  endtask

  task automatic checkRead(int a, string req);
    regAddr = AW'(a);
    #1;
    chk(req, 64'(regRdata), 64'(expRead(a)));
  endtask

  task automatic checkPads(string req);
    chk(req, {pinDout, pinPullUp, pinOpenDrain, pinOe}, expPads());
    chk(req, 64'(funcSel), 64'(mFsel));
  endtask

  task automatic checkAll(string req);
    for (int a = 0; a <= NP; a++) checkRead(a, req);
    checkPads(req);
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    #3;
    // R1: outputs cleared during reset
    chk("R1 pads in reset", {pinDout, pinPullUp, pinOpenDrain, pinOe}, '0);
    @(negedge clk);
    rstN = 1'b1;
    checkAll("R1");

    // R2 R3: plain write, reserved bits dropped
    doWrite(3, 8'h7B);
    checkRead(3, "R2");
    checkPads("R11");
    // R4: lock together with attributes
    doWrite(3, 8'hF5);
    checkRead(3, "R4 same write");
    chk("R4 read value", 64'(regRdata), 64'h85);
    doWrite(3, 8'h0A);
    checkRead(3, "R4 dropped write");
    checkPads("R4");
    // R6: software cannot clear a lock
    doWrite(3, 8'h00);
    checkRead(3, "R6");
    // R5: neighbour stays writable
    doWrite(4, 8'h0F);
    checkRead(4, "R5");
    doWrite(2, 8'h06);
    checkRead(2, "R5");
    // R7: global register
    doWrite(NP, 8'h2A);
    checkRead(NP, "R7");
    doWrite(NP, 8'hD5);
    checkRead(NP, "R7 lock same write");
    doWrite(NP, 8'h00);
    checkRead(NP, "R8");
    checkPads("R7");
    // R9: global lock does not protect pins
    doWrite(5, 8'h09);
    checkRead(5, "R9");
    // R10: unmapped addresses
    doWrite(20, 8'hFF);
    checkRead(20, "R10 read");
    doWrite(31, 8'h7F);
    checkRead(31, "R10 read");
    checkAll("R10");
    // R1 R6 R8: reset clears locks
    doReset();
    checkAll("R1 after reset");
    doWrite(3, 8'h01);
    checkRead(3, "R6 after reset");
    doWrite(NP, 8'h11);
    checkRead(NP, "R8 after reset");

    // Random phase
    void'($urandom(32'd4242));
    for (int n = 0; n < 600; n++) begin
      int a;
      logic [7:0] d;
      a = int'($urandom_range(0, 22));
      d = 8'($urandom);
      if ($urandom_range(0, 15) != 0) d[7] = 1'b0;
      doWrite(a, d);
      checkRead(a, "R3 random");
      checkPads("R11 random");
      if (n == 300) begin
        doReset();
        checkAll("R1 random reset");
      end
    end
    checkAll("R5 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule